// File: doc/BRIEF.md
# Nested Segment Protection Checker

This block decides, for every access on a flat address, whether the access may proceed. It does no address translation. Addresses reach it already resolved, and it only grants or refuses them. Software builds up a small hardware stack of nested protection segments. The outermost region, such as a whole process space, sits at the bottom. Narrower regions such as a data area, a heap and a single buffer are pushed above it. Each segment is a descriptor holding a base, a limit, read/write/execute rights and the ID of the thread that loaded it.

Rights only narrow as the nesting deepens. When a descriptor is pushed, its rights are ANDed with the effective rights of the entry beneath it, so that only the top entry has to be examined on an access. Two extra top-level slots, A and B, let a thread work on two buffers at once, for example the source and destination of a copy. Slot A can later be moved down onto the stack. A request that carries an address, the requested rights and a thread ID is answered one cycle later with allow or fault. Stack misuse sets a sticky error flag.

Top module: `seg_guard`

## Requirements
- R1: After reset the stack is empty, both slots are invalid and the error flag is low, so every access is answered with fault.
- R2: Each cycle with acc_valid high is answered in the next cycle with exactly one of acc_allow or acc_fault high. Both outputs are low in the cycle after a cycle without a request.
- R3: A descriptor covers addresses from base to base+limit, with both ends included. An address below base or above base+limit does not match it.
- R4: Rights are three bits: bit 0 read, bit 1 write, bit 2 execute. An access matches only if every requested bit is set in the descriptor's effective rights.
- R5: An access matches a descriptor only if acc_tid equals the thread ID stored with that descriptor.
- R6: Push (op_kind 0) stores the descriptor with rights ANDed with the current top's rights, or unchanged when the stack is empty. Only the top stack entry is checked, and lower entries never grant an access. The default depth is 8.
- R7: Pop (op_kind 1) removes the top entry, and the entry beneath becomes the one checked.
- R8: A push onto a full stack or a pop from an empty stack sets err_flag and leaves the stack unchanged. err_flag stays high until reset.
- R9: Load A (op_kind 2) and load B (op_kind 3) place the descriptor in that slot, with rights ANDed with the current top's rights (unchanged if the stack is empty). An access is allowed if slot A, slot B or the stack top matches it.
- R10: A slot records the stack depth at which it was loaded. A pop that removes the entry directly beneath it invalidates the slot.
- R11: Push-through (op_kind 4) pushes slot A's descriptor onto the stack, with rights ANDed again with the current top, and invalidates slot A. If slot A is invalid or the stack is full, it sets err_flag and changes nothing.
- R12: op_kind values 5 to 7 have no effect. An access in the same cycle as an operation is judged against the state before that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Stack/slot operation strobe |
| op_kind | input | 3 | 0 push, 1 pop, 2 load A, 3 load B, 4 push-through A |
| op_base | input | 32 | Descriptor base address |
| op_limit | input | 32 | Descriptor limit (last byte offset) |
| op_rights | input | 3 | Descriptor rights: bit0 read, bit1 write, bit2 execute |
| op_tid | input | 8 | Thread ID of the loading thread |
| acc_valid | input | 1 | Access request strobe |
| acc_addr | input | 32 | Flat access address |
| acc_rights | input | 3 | Requested rights, same encoding |
| acc_tid | input | 8 | Requesting thread ID |
| acc_allow | output | 1 | Access granted (one cycle after request) |
| acc_fault | output | 1 | Access refused (one cycle after request) |
| err_flag | output | 1 | Sticky stack misuse flag |

## Verification
The allow/fault answer to a request is due in the clock edge that follows it. Any change to the stack, a slot or the error flag caused by an operation is visible at that same edge, and it first affects requests presented in the next cycle. The bench drives each request and operation half a cycle before an edge. It predicts the answer from its model's state before the operation, then advances the model, and compares acc_allow, acc_fault and err_flag half a cycle after the edge. Requests in the same cycle as a pop therefore check that the pre-operation state is used.

// File: rtl/segchk_pkg.sv
package segchk_pkg;
    parameter int unsigned SEG_AW = 32;
    parameter int unsigned SEG_TW = 8;
    parameter int unsigned SEG_RW = 3;

    typedef enum logic [2:0] {
        OP_PUSH   = 3'd0,
        OP_POP    = 3'd1,
        OP_LOAD_A = 3'd2,
        OP_LOAD_B = 3'd3,
        OP_THRU_A = 3'd4
    } op_e;

    typedef struct packed {
        logic [SEG_AW-1:0] base;
        logic [SEG_AW-1:0] limit;
        logic [SEG_RW-1:0] rights;
        logic [SEG_TW-1:0] tid;
    } desc_t;
endpackage

// File: rtl/seg_window.sv
module seg_window
    import segchk_pkg::*;
(
    input  desc_t             desc,
    input  logic              desc_vld,
    input  logic [SEG_AW-1:0] addr,
    input  logic [SEG_RW-1:0] rights,
    input  logic [SEG_TW-1:0] tid,
    output logic              hit
);
    logic [SEG_AW-1:0] offset;
    logic              in_range;
    logic              rights_ok;

    always_comb begin
        offset    = addr - desc.base;
        in_range  = (addr >= desc.base) && (offset <= desc.limit);
        rights_ok = (rights & ~desc.rights) == '0;
        hit       = desc_vld && in_range && rights_ok && (tid == desc.tid);
    end
endmodule

// File: rtl/seg_stack.sv
module seg_stack
    import segchk_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  desc_t            push_desc,
    output desc_t            top_desc,
    output logic [LVL_W-1:0] depth
);
    typedef struct packed {
        desc_t [DEPTH-1:0] ent;
        logic [LVL_W-1:0]  cnt;
    } stk_t;

    stk_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        top_desc = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_q.cnt == LVL_W'(i + 1)) top_desc = st_q.ent[i];
        end
        if (push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (st_q.cnt == LVL_W'(i)) st_d.ent[i] = push_desc;
            end
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (pop) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign depth = st_q.cnt;
endmodule

// File: rtl/seg_guard.sv
module seg_guard
    import segchk_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1),
    localparam int unsigned N_CAND = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_kind,
    input  logic [SEG_AW-1:0] op_base,
    input  logic [SEG_AW-1:0] op_limit,
    input  logic [SEG_RW-1:0] op_rights,
    input  logic [SEG_TW-1:0] op_tid,
    input  logic              acc_valid,
    input  logic [SEG_AW-1:0] acc_addr,
    input  logic [SEG_RW-1:0] acc_rights,
    input  logic [SEG_TW-1:0] acc_tid,
    output logic              acc_allow,
    output logic              acc_fault,
    output logic              err_flag
);
    typedef struct packed {
        desc_t            d;
        logic             vld;
        logic [LVL_W-1:0] lvl;
    } slot_t;

    typedef struct packed {
        slot_t a;
        slot_t b;
        logic  err;
        logic  allow;
        logic  fault;
    } state_t;

    state_t           st_d, st_q;
    desc_t            top_desc;
    logic [LVL_W-1:0] stk_depth;
    logic             stk_push, stk_pop;
    desc_t            stk_in;
    logic             top_vld, full;
    desc_t            op_desc;
    desc_t            cand_desc [N_CAND];
    logic             cand_vld  [N_CAND];
    logic [N_CAND-1:0] cand_hit;

    seg_stack #(.DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (stk_push),
        .pop       (stk_pop),
        .push_desc (stk_in),
        .top_desc  (top_desc),
        .depth     (stk_depth)
    );

    assign top_vld = stk_depth != '0;
    assign full    = stk_depth == LVL_W'(DEPTH);

    always_comb begin
        cand_desc[0] = top_desc;   cand_vld[0] = top_vld;
        cand_desc[1] = st_q.a.d;   cand_vld[1] = st_q.a.vld;
        cand_desc[2] = st_q.b.d;   cand_vld[2] = st_q.b.vld;
    end

    for (genvar g = 0; g < N_CAND; g++) begin : g_win
        seg_window u_win (
            .desc     (cand_desc[g]),
            .desc_vld (cand_vld[g]),
            .addr     (acc_addr),
            .rights   (acc_rights),
            .tid      (acc_tid),
            .hit      (cand_hit[g])
        );
    end

    function automatic desc_t fold(input desc_t d, input logic tv, input desc_t t);
        desc_t r;
        r = d;
        if (tv) r.rights = d.rights & t.rights;
        return r;
    endfunction

    always_comb begin
        st_d     = st_q;
        stk_push = 1'b0;
        stk_pop  = 1'b0;
        stk_in   = '0;
        op_desc  = '{base: op_base, limit: op_limit, rights: op_rights, tid: op_tid};

        st_d.allow = acc_valid && (cand_hit != '0);
        st_d.fault = acc_valid && (cand_hit == '0);

        if (op_valid) begin
            case (op_e'(op_kind))
                OP_PUSH: begin
                    if (full) st_d.err = 1'b1;
                    else begin
                        stk_push = 1'b1;
                        stk_in   = fold(op_desc, top_vld, top_desc);
                    end
                end
                OP_POP: begin
                    if (!top_vld) st_d.err = 1'b1;
                    else begin
                        stk_pop = 1'b1;
                        if (st_q.a.lvl == stk_depth) st_d.a.vld = 1'b0;
                        if (st_q.b.lvl == stk_depth) st_d.b.vld = 1'b0;
                    end
                end
                OP_LOAD_A: st_d.a = '{d: fold(op_desc, top_vld, top_desc), vld: 1'b1, lvl: stk_depth};
                OP_LOAD_B: st_d.b = '{d: fold(op_desc, top_vld, top_desc), vld: 1'b1, lvl: stk_depth};
                OP_THRU_A: begin
                    if (!st_q.a.vld || full) st_d.err = 1'b1;
                    else begin
                        stk_push   = 1'b1;
                        stk_in     = fold(st_q.a.d, top_vld, top_desc);
                        st_d.a.vld = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_allow = st_q.allow;
    assign acc_fault = st_q.fault;
    assign err_flag  = st_q.err;
endmodule

// File: rtl/seg_guard_chk.sv
module seg_guard_chk #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned LVL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [2:0]       op_kind,
    input logic             acc_valid,
    input logic             acc_allow,
    input logic             acc_fault,
    input logic             err_flag,
    input logic [LVL_W-1:0] depth
);
    a_r2_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (acc_allow ^ acc_fault));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !(acc_allow || acc_fault));

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    a_r8_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 3'd1 && depth == '0) |=> (err_flag && depth == '0));

    a_r8_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 3'd0 && depth == LVL_W'(DEPTH)) |=> (err_flag && $stable(depth)));

    a_r6_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= LVL_W'(DEPTH));
endmodule

bind seg_guard seg_guard_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_seg_guard_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_kind   (op_kind),
    .acc_valid (acc_valid),
    .acc_allow (acc_allow),
    .acc_fault (acc_fault),
    .err_flag  (err_flag),
    .depth     (stk_depth)
);

// File: tb/test_seg_guard.sv
module test_seg_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_kind = '0;
    logic [31:0] op_base = '0, op_limit = '0;
    logic [2:0]  op_rights = '0;
    logic [7:0]  op_tid = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [2:0]  acc_rights = '0;
    logic [7:0]  acc_tid = '0;
    logic        acc_allow, acc_fault, err_flag;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    seg_guard i_seg_guard (.*);

    typedef struct {
        logic [31:0] b;
        logic [31:0] l;
        logic [2:0]  r;
        logic [7:0]  t;
    } d_t;

    d_t   stk[$];
    d_t   sa, sb;
    bit   sa_v, sb_v;
    int   sa_lvl, sb_lvl;
    bit   m_err;

    function automatic d_t mk(logic [31:0] b, logic [31:0] l, logic [2:0] r, logic [7:0] t);
        d_t d;
        d.b = b; d.l = l; d.r = r; d.t = t;
        return d;
    endfunction

    function automatic bit covers(d_t d, logic [31:0] a, logic [2:0] r, logic [7:0] t);
        longint unsigned hi;
        hi = longint'(d.b) + longint'(d.l);
        return (a >= d.b) && (longint'(a) <= hi) && ((r & ~d.r) == 3'b000) && (t == d.t);
    endfunction

    function automatic d_t narrow(d_t d);
        d_t x;
        x = d;
        if (stk.size() > 0) x.r = d.r & stk[stk.size()-1].r;
        return x;
    endfunction

    task automatic check(string req, string what, logic act, logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        stk.delete();
        sa_v = 0; sb_v = 0; sa_lvl = 0; sb_lvl = 0; m_err = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op_valid = 1'b0; acc_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // op < 0 means no operation
    task automatic step(int op, d_t d, bit av, logic [31:0] aa, logic [2:0] ar, logic [7:0] at, string req);
        bit e_allow, e_fault;
        op_valid   = (op >= 0);
        op_kind    = (op >= 0) ? 3'(op) : 3'd0;
        op_base    = d.b; op_limit = d.l; op_rights = d.r; op_tid = d.t;
        acc_valid  = av; acc_addr = aa; acc_rights = ar; acc_tid = at;
        e_allow = 0;
        if (stk.size() > 0 && covers(stk[stk.size()-1], aa, ar, at)) e_allow = 1;
        if (sa_v && covers(sa, aa, ar, at)) e_allow = 1;
        if (sb_v && covers(sb, aa, ar, at)) e_allow = 1;
        e_fault = av && !e_allow;
        e_allow = av && e_allow;
        @(posedge clk);
        case (op)
            0: if (stk.size() == 8) m_err = 1; else stk.push_back(narrow(d));
            1: if (stk.size() == 0) m_err = 1;
               else begin
                   if (sa_v && sa_lvl == stk.size()) sa_v = 0;
                   if (sb_v && sb_lvl == stk.size()) sb_v = 0;
                   void'(stk.pop_back());
               end
            2: begin sa = narrow(d); sa_v = 1; sa_lvl = stk.size(); end
            3: begin sb = narrow(d); sb_v = 1; sb_lvl = stk.size(); end
            4: if (!sa_v || stk.size() == 8) m_err = 1;
               else begin stk.push_back(narrow(sa)); sa_v = 0; end
            default: ;
        endcase
        @(negedge clk);
        check(req, "acc_allow", acc_allow, e_allow);
        check(req, "acc_fault", acc_fault, e_fault);
        check(req, "err_flag", err_flag, m_err);
    endtask

    d_t z;

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        z = mk(0, 0, 0, 0);
        model_reset();
        do_reset();
        // R1: reset state
        check("R1", "acc_allow", acc_allow, 1'b0);
        check("R1", "err_flag", err_flag, 1'b0);
        step(-1, z, 1, 32'h100, 3'b001, 8'd5, "R1");
        step(-1, z, 0, 32'h100, 3'b001, 8'd5, "R2");
        // R6 push base segment, R3 bounds
        step(0, mk(0, 32'hFFFF, 3'b111, 8'd5), 0, 0, 0, 0, "R6");
        step(-1, z, 1, 32'h100, 3'b001, 8'd5, "R3");
        step(-1, z, 1, 32'hFFFF, 3'b001, 8'd5, "R3");
        step(-1, z, 1, 32'h10000, 3'b001, 8'd5, "R3");
        // R5 thread mismatch
        step(-1, z, 1, 32'h100, 3'b001, 8'd6, "R5");
        // R4 rights, R6 only top checked
        step(0, mk(32'h1000, 32'hFF, 3'b011, 8'd5), 0, 0, 0, 0, "R6");
        step(-1, z, 1, 32'h1000, 3'b100, 8'd5, "R4");
        step(-1, z, 1, 32'h10FF, 3'b010, 8'd5, "R4");
        step(-1, z, 1, 32'h0FFF, 3'b001, 8'd5, "R3");
        step(-1, z, 1, 32'h2000, 3'b001, 8'd5, "R6");
        step(0, mk(32'h1010, 32'h20, 3'b110, 8'd5), 0, 0, 0, 0, "R6");
        step(-1, z, 1, 32'h1010, 3'b001, 8'd5, "R6");
        step(-1, z, 1, 32'h1010, 3'b010, 8'd5, "R6");
        step(-1, z, 1, 32'h1010, 3'b100, 8'd5, "R6");
        // R9 slots
        step(2, mk(32'h4000, 32'h10, 3'b111, 8'd5), 0, 0, 0, 0, "R9");
        step(3, mk(32'h5000, 32'h0, 3'b111, 8'd9), 0, 0, 0, 0, "R9");
        step(-1, z, 1, 32'h4005, 3'b010, 8'd5, "R9");
        step(-1, z, 1, 32'h4005, 3'b001, 8'd5, "R9");
        step(-1, z, 1, 32'h5000, 3'b010, 8'd9, "R9");
        step(-1, z, 1, 32'h5001, 3'b010, 8'd9, "R9");
        step(-1, z, 1, 32'h1010, 3'b010, 8'd5, "R9");
        // R12: access with pop judged on old state; R10 slots die
        step(1, z, 1, 32'h4005, 3'b010, 8'd5, "R12");
        step(-1, z, 1, 32'h4005, 3'b010, 8'd5, "R10");
        step(-1, z, 1, 32'h5000, 3'b010, 8'd9, "R10");
        step(-1, z, 1, 32'h1000, 3'b001, 8'd5, "R7");
        step(-1, z, 1, 32'h1010, 3'b001, 8'd5, "R7");
        // R12 unused codes
        for (int k = 5; k < 8; k++) step(k, mk(32'h9000, 32'hF, 3'b111, 8'd5), 0, 0, 0, 0, "R12");
        step(-1, z, 1, 32'h9000, 3'b001, 8'd5, "R12");
        step(-1, z, 1, 32'h1000, 3'b001, 8'd5, "R12");
        // R8 fill to full, overflow
        for (int i = 0; i < 6; i++) step(0, mk(32'h1000 + 32'(i), 32'h40, 3'b111, 8'd5), 0, 0, 0, 0, "R8");
        step(0, mk(32'h8000, 32'hF, 3'b111, 8'd5), 0, 0, 0, 0, "R8");
        step(-1, z, 1, 32'h8000, 3'b001, 8'd5, "R8");
        step(-1, z, 1, 32'h1045, 3'b010, 8'd5, "R8");
        for (int i = 0; i < 8; i++) step(1, z, 1, 32'h1006, 3'b001, 8'd5, "R7");
        step(1, z, 1, 32'h0, 3'b001, 8'd5, "R8");
        // R11 push-through
        do_reset();
        check("R1", "err_flag", err_flag, 1'b0);
        step(3, mk(32'h7000, 32'h3, 3'b100, 8'd2), 0, 0, 0, 0, "R9");
        step(-1, z, 1, 32'h7003, 3'b100, 8'd2, "R9");
        step(0, mk(0, 32'hFFFFFFFF, 3'b101, 8'd1), 0, 0, 0, 0, "R6");
        step(-1, z, 1, 32'hFFFFFFFF, 3'b100, 8'd1, "R3");
        step(2, mk(32'h6000, 32'h7, 3'b111, 8'd1), 0, 0, 0, 0, "R9");
        step(0, mk(32'h100, 32'h100, 3'b001, 8'd1), 0, 0, 0, 0, "R6");
        step(-1, z, 1, 32'h6000, 3'b100, 8'd1, "R9");
        step(4, z, 0, 0, 0, 0, "R11");
        step(-1, z, 1, 32'h6007, 3'b001, 8'd1, "R11");
        step(-1, z, 1, 32'h6007, 3'b100, 8'd1, "R11");
        step(-1, z, 1, 32'h150, 3'b001, 8'd1, "R11");
        step(1, z, 0, 0, 0, 0, "R11");
        step(-1, z, 1, 32'h150, 3'b001, 8'd1, "R11");
        step(4, z, 0, 0, 0, 0, "R11");
        step(-1, z, 0, 0, 0, 0, "R8");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule